// File: doc/BRIEF.md
# Reed-Solomon Sector Parity Engine

This block sits in the byte stream between a host bus and a NAND flash array. It computes a shortened Reed-Solomon code over GF(2^10) for one sector. The field polynomial is x^10 + x^3 + 1. The generator has degree 6, with roots alpha^0 to alpha^5. Each data byte is inverted and widened to a 10-bit symbol (upper two bits zero) before it enters a six-stage parity divider. Because of the inversion, an erased sector of all 0xFF produces parity bytes that are also all 0xFF.

**Generate mode.** While a sector is written, the host starts generate mode and streams the data through the block. Afterwards it freezes the engine and reads eight parity bytes to store in the spare area.

**Check mode.** While a sector is read, the host starts check mode and streams the data followed by the eight stored parity bytes. The engine then reports whether the received codeword leaves a nonzero remainder. It also exposes the 60-bit remainder in a second window, so that software can locate and correct errors.

**Register map.** All registers are eight bits wide and read combinationally:

| Address | Register |
|---|---|
| 0x00 | Control |
| 0x01 | Status |
| 0x08–0x0F | Parity window |
| 0x10–0x17 | Remainder window |

Top module: `rs_ecc_engine`

## Requirements
- R1: After reset the control and status registers read 0x00, every parity window byte reads 0xFF and every remainder window byte reads 0x00.
- R2: In generate mode, after SECTOR_BYTES accepted bytes, parity window byte i bit b equals the inverse of bit 8i+7-b of a 64-bit vector V. In V, bits 10k..10k+9 hold the coefficient of x^(5-k) of the remainder of (inverted data polynomial) times x^6 divided by the generator, and bits 60..63 are zero. The first data byte is the highest-order coefficient.
- R3: A sector of all 0xFF bytes in generate mode yields eight parity bytes of 0xFF.
- R4: In check mode, a sector followed by its own eight parity bytes leaves status bit 7 clear and all remainder window bytes at 0x00.
- R5: In check mode, one to three corrupted data bytes set status bit 7. Remainder window byte i then equals bits 8i..8i+7 of V(received data) XOR V(original data), with the same field packing as in R2.
- R6: A byte is accepted only when byte_valid is high in a cycle where control bit 5 (feed enable) is set. Bytes offered with valid low or feed disabled leave the parity and remainder unchanged.
- R7: Writing control with bit 7 set clears the divider, the byte count and the stored parity in that cycle. Bits 6 (generate) and 5 (feed) are stored and read back, and bit 7 always reads 0.
- R8: Bytes beyond SECTOR_BYTES in generate mode, and beyond SECTOR_BYTES+8 in check mode, are ignored.
- R9: Status bit 7 is set only in check mode once SECTOR_BYTES+8 bytes have been accepted. It stays clear while any stored parity byte is still missing.
- R10: The low four bits of the last parity window byte (address 0x0F) always read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Stream byte strobe |
| byte_data | input | 8 | Stream byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
The properties assume the following about the host:
- Control writes come from a single master.
- The mode bit is not changed without a clear once the check-mode parity bytes have begun. The flag and count properties rely on this.

The stimulus keeps within these assumptions:
- Every scenario begins with a control write that sets bit 7.
- Feeding is stopped only by writing zero.
- Bytes are driven on the falling edge, one per cycle, with occasional idle gaps.

Register reads are sampled a step after the address settles.

// File: rtl/rs_ecc_engine.sv
module rs_ecc_engine #(
  parameter int SECTOR_BYTES = 512,
  parameter logic [10:0] FIELD_POLY = 11'h409,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  localparam int SYM_W = 10;
  localparam int NPAR = 6;
  localparam int ECC_BYTES = 8;
  localparam int VEC_W = ECC_BYTES * 8;
  localparam int TOTAL = SECTOR_BYTES + ECC_BYTES;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [ADDR_W-1:0] A_CTL = 0;
  localparam logic [ADDR_W-1:0] A_STAT = 1;
  localparam logic [ADDR_W-1:0] A_PWIN = 8;
  localparam logic [ADDR_W-1:0] A_RWIN = 16;

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc, x;
    acc = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc ^= x;
      x = x[SYM_W-1] ? ({x[SYM_W-2:0], 1'b0} ^ FIELD_POLY[SYM_W-1:0]) : {x[SYM_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [NPAR*SYM_W-1:0] gen_poly();
    logic [SYM_W-1:0] c [NPAR+1];
    logic [SYM_W-1:0] root;
    logic [NPAR*SYM_W-1:0] packed_c;
    for (int j = 0; j <= NPAR; j++) c[j] = '0;
    c[0] = 1;
    root = 1;
    for (int i = 0; i < NPAR; i++) begin
      for (int j = NPAR; j >= 1; j--) c[j] = c[j-1] ^ gf_mul(c[j], root);
      c[0] = gf_mul(c[0], root);
      root = gf_mul(root, SYM_W'(2));
    end
    for (int j = 0; j < NPAR; j++) packed_c[j*SYM_W +: SYM_W] = c[j];
    return packed_c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  localparam logic [NPAR*SYM_W-1:0] GEN = gen_poly();

  logic                            gen_q, feed_q;
  logic [CNT_W-1:0]                cnt_q;
  logic [NPAR-1:0][SYM_W-1:0]      par_q, par_nxt;
  logic [ECC_BYTES-1:0][7:0]       stored_q;
  logic [SYM_W-1:0]                fb;
  logic [VEC_W-1:0]                pvec, pinv, svec, rvec;
  logic                            ctl_wr, clr, take, in_data, err;
  logic [2:0]                      sidx;

  assign ctl_wr  = reg_we && reg_addr == A_CTL;
  assign clr     = ctl_wr && reg_wdata[7];
  assign in_data = cnt_q < CNT_W'(SECTOR_BYTES);
  assign take    = byte_valid && feed_q && !clr &&
                   (gen_q ? in_data : cnt_q < CNT_W'(TOTAL));
  assign sidx    = 3'(cnt_q - CNT_W'(SECTOR_BYTES));
  assign fb      = {2'b00, ~byte_data} ^ par_q[NPAR-1];

  assign par_nxt[0] = gf_mul(fb, GEN[0 +: SYM_W]);
  for (genvar j = 1; j < NPAR; j++) begin : g_stage
    assign par_nxt[j] = par_q[j-1] ^ gf_mul(fb, GEN[j*SYM_W +: SYM_W]);
  end

  for (genvar k = 0; k < NPAR; k++) begin : g_pack
    assign pvec[k*SYM_W +: SYM_W] = par_q[NPAR-1-k];
  end
  assign pvec[VEC_W-1:NPAR*SYM_W] = '0;
  assign pinv = ~pvec;

  for (genvar i = 0; i < ECC_BYTES; i++) begin : g_unpack
    assign svec[i*8 +: 8] = rev8(stored_q[i]);
  end
  assign rvec = {{(VEC_W-NPAR*SYM_W){1'b0}}, pvec[NPAR*SYM_W-1:0] ^ ~svec[NPAR*SYM_W-1:0]};
  assign err  = !gen_q && cnt_q == CNT_W'(TOTAL) && |rvec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      feed_q <= 1'b0;
    end else if (ctl_wr) begin
      gen_q  <= reg_wdata[6];
      feed_q <= reg_wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q    <= '0;
      par_q    <= '0;
      stored_q <= '1;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (in_data) par_q <= par_nxt;
      else stored_q[sidx] <= byte_data;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == A_CTL) reg_rdata = {1'b0, gen_q, feed_q, 5'b0};
    else if (reg_addr == A_STAT) reg_rdata = {err, 7'b0};
    else if (reg_addr >= A_PWIN && reg_addr < A_PWIN + ADDR_W'(ECC_BYTES))
      reg_rdata = rev8(pinv[reg_addr[2:0]*8 +: 8]);
    else if (reg_addr >= A_RWIN && reg_addr < A_RWIN + ADDR_W'(ECC_BYTES))
      reg_rdata = rvec[reg_addr[2:0]*8 +: 8];
  end
endmodule

module rs_ecc_engine_checker #(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W = 5,
  parameter int CNT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              feed,
  input logic              gen,
  input logic [CNT_W-1:0]  cnt,
  input logic [59:0]       par
);
  localparam int TOTAL = SECTOR_BYTES + 8;
  logic clr_w;
  assign clr_w = reg_we && reg_addr == '0 && reg_wdata[7];

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (cnt == '0 && par == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(byte_valid && feed) && !clr_w) |=> ($stable(par) && $stable(cnt)));

  assert_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TOTAL));

  assert_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1) && reg_rdata[7]) |-> (cnt == CNT_W'(TOTAL) && !gen));

  assert_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(15)) |-> (reg_rdata[3:0] == 4'hF));
endmodule

bind rs_ecc_engine rs_ecc_engine_checker #(
  .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .feed(feed_q), .gen(gen_q), .cnt(cnt_q), .par(par_q)
);

// File: tb/rs_ecc_engine_bench.sv
module rs_ecc_engine_bench;
  localparam int SEC = 512;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, byte_valid, reg_we;
  logic [7:0] byte_data, reg_wdata, reg_rdata;
  logic [4:0] reg_addr;
  int n_chk = 0, n_bad = 0;
  logic [7:0] dat [SEC];
  logic [9:0] gd [7];

  rs_ecc_engine u_rs_ecc_engine (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [9:0] fmul(input logic [9:0] a, input logic [9:0] b);
    logic [9:0] acc = '0;
    for (int i = 9; i >= 0; i--) begin
      acc = {acc[8:0], 1'b0} ^ (acc[9] ? 10'h009 : 10'h000);
      if (a[i]) acc ^= b;
    end
    return acc;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic build_gen();
    logic [9:0] r = 10'd1;
    for (int k = 0; k < 7; k++) gd[k] = '0;
    gd[0] = 10'd1;
    for (int i = 0; i < 6; i++) begin
      for (int k = i + 1; k >= 1; k--) gd[k] = gd[k] ^ fmul(r, gd[k-1]);
      r = fmul(r, 10'd2);
    end
  endtask

  function automatic logic [63:0] model_vec();
    logic [9:0] w [SEC+6];
    logic [63:0] v = '0;
    for (int i = 0; i < SEC + 6; i++) w[i] = (i < SEC) ? {2'b00, ~dat[i]} : 10'd0;
    for (int i = 0; i < SEC; i++)
      for (int j = 1; j <= 6; j++) w[i+j] ^= fmul(w[i], gd[j]);
    for (int k = 0; k < 6; k++) v[k*10 +: 10] = w[SEC+k];
    return v;
  endfunction

  function automatic logic [7:0] pbyte(input logic [63:0] v, input int i);
    logic [63:0] n = ~v;
    return rev8(n[i*8 +: 8]);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic push_data(input int gap_every);
    for (int i = 0; i < SEC; i++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_data = dat[i];
      if (gap_every != 0 && i % gap_every == 0) begin
        @(negedge clk);
        byte_valid = 1'b0; byte_data = 8'h5A;
      end
    end
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic push_parity(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) push(pbyte(v, i));
  endtask

  task automatic fill(input int kind, input int seed);
    logic [31:0] s = 32'(seed) | 32'd1;
    for (int i = 0; i < SEC; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      case (kind)
        0: dat[i] = 8'(i);
        1: dat[i] = 8'hFF;
        2: dat[i] = 8'h00;
        default: dat[i] = s[7:0];
      endcase
    end
  endtask

  task automatic check_par(input string tag, input logic [63:0] v);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(5'(8 + i), d);
      check(tag, d, pbyte(v, i));
    end
  endtask

  task automatic check_rem(input string tag, input logic [63:0] v);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(5'(16 + i), d);
      check(tag, d, v[i*8 +: 8]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(5'd0, d); check("R1 control after reset", d, 8'h00);
    rd(5'd1, d); check("R1 status after reset", d, 8'h00);
    check_par("R1 parity after reset", 64'd0);
    check_rem("R1 remainder after reset", 64'd0);
  endtask

  task automatic t_generate(input int kind, input int seed, input int gap);
    logic [63:0] v;
    logic [7:0] d;
    fill(kind, seed);
    v = model_vec();
    wr(5'd0, 8'hE0);
    push_data(gap);
    wr(5'd0, 8'h00);
    check_par("R2 generated parity", v);
    rd(5'd15, d); check("R10 padding nibble", {4'h0, d[3:0]}, 8'h0F);
  endtask

  task automatic t_erased();
    fill(1, 0);
    wr(5'd0, 8'hE0);
    push_data(0);
    wr(5'd0, 8'h00);
    check_par("R3 erased sector parity", 64'd0);
  endtask

  task automatic t_clean(input int kind, input int seed);
    logic [63:0] v;
    logic [7:0] d;
    fill(kind, seed);
    v = model_vec();
    wr(5'd0, 8'hA0);
    push_data(0);
    push_parity(v, 8);
    wr(5'd0, 8'h00);
    rd(5'd1, d); check("R4 clean status", d, 8'h00);
    check_rem("R4 clean remainder", 64'd0);
  endtask

  task automatic t_errors(input int nerr);
    logic [63:0] vg, vb;
    logic [7:0] d;
    fill(3, 77 + nerr);
    vg = model_vec();
    for (int e = 0; e < nerr; e++) dat[37 + e * 101] = dat[37 + e * 101] ^ 8'(8'h11 << e | 8'h01);
    vb = model_vec();
    wr(5'd0, 8'hA0);
    push_data(0);
    push_parity(vg, 8);
    wr(5'd0, 8'h00);
    rd(5'd1, d); check($sformatf("R5 status with %0d errors", nerr), d, 8'h80);
    check_rem("R5 remainder value", vg ^ vb);
  endtask

  task automatic t_ignore();
    logic [63:0] v;
    fill(3, 1234);
    v = model_vec();
    wr(5'd0, 8'hE0);
    push_data(3);
    wr(5'd0, 8'h00);
    check_par("R6 parity with idle gaps", v);
    for (int i = 0; i < 20; i++) push(8'(i * 7));
    check_par("R6 parity unchanged when feed off", v);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    fill(0, 0);
    wr(5'd0, 8'hE0);
    rd(5'd0, d); check("R7 control readback", d, 8'h60);
    for (int i = 0; i < 40; i++) push(dat[i]);
    wr(5'd0, 8'hE0);
    rd(5'd0, d); check("R7 clear bit reads zero", d, 8'h60);
    check_par("R7 parity after clear", 64'd0);
    wr(5'd0, 8'h80);
    rd(5'd0, d); check("R7 control after plain clear", d, 8'h00);
  endtask

  task automatic t_overrun();
    logic [63:0] v;
    logic [7:0] d;
    fill(3, 999);
    v = model_vec();
    wr(5'd0, 8'hE0);
    push_data(0);
    for (int i = 0; i < 10; i++) push(8'hC3);
    wr(5'd0, 8'h00);
    check_par("R8 generate extra bytes ignored", v);
    wr(5'd0, 8'hA0);
    push_data(0);
    push_parity(v, 8);
    for (int i = 0; i < 5; i++) push(8'h3C);
    rd(5'd1, d); check("R8 check extra bytes ignored", d, 8'h00);
    wr(5'd0, 8'h00);
  endtask

  task automatic t_partial();
    logic [63:0] vg;
    logic [7:0] d;
    fill(0, 0);
    vg = model_vec();
    dat[100] = dat[100] ^ 8'h40;
    wr(5'd0, 8'hA0);
    push_data(0);
    push_parity(vg, 7);
    rd(5'd1, d); check("R9 no flag before last parity byte", d, 8'h00);
    push(pbyte(vg, 7));
    rd(5'd1, d); check("R9 flag after last parity byte", d, 8'h80);
    wr(5'd0, 8'h00);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    build_gen();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_generate(0, 0, 0);
    t_generate(3, 42, 0);
    t_generate(2, 0, 0);
    t_erased();
    t_clean(0, 0);
    t_clean(3, 5);
    t_errors(1);
    t_errors(2);
    t_errors(3);
    t_ignore();
    t_clear();
    t_overrun();
    t_partial();
    finish_run();
  end
endmodule